// File: doc/BRIEF.md
# Scanline Sprite Evaluator with Skewed Overflow Search

This block chooses the sprites for the next scanline. It reads a 256-byte sprite attribute memory of 64 sprites, each 4 bytes long, during dots 65 to 256 of every line. The first byte of each sprite is its vertical position. Each sprite whose vertical position covers the current scanline is copied, all four bytes, into an eight-slot secondary buffer. After eight sprites have been taken, the block keeps reading so that it can raise an overflow flag.

That later search copies a known hardware fault. During the copy phase, an out-of-range sprite makes the next read start at byte 0 of the following sprite. Once the buffer is full, the same skip moves both the sprite index and the byte offset forward. The search therefore steps diagonally through the attribute bytes and treats tile, attribute or X bytes as if they were vertical positions. The flag can be wrong in either direction, and that is the intended behaviour.

One clock is one dot, and the dot number comes in from outside. The attribute memory is read combinationally: the block drives an address and expects the byte on the same cycle. The secondary buffer is a plain write strobe with address and data and has no back-pressure. Its timing is fixed by the dot count, so the buffer must accept a write on any cycle in which the strobe is high.

Top module: `sprite_eval`

## Requirements
- R1: After reset the overflow flag is 0, the attribute address is 0, and no secondary write occurs until an evaluation window has begun.
- R2: The attribute address has the sprite index in bits 7:2 and the byte offset in bits 1:0. It is presented on the first dot of each two-dot pair (dots 65, 67, …) and holds through the second dot of that pair, so one address step takes two dots.
- R3: A byte Y counts as in range when (scanline − Y) mod 256 is below 8, or below 16 when `tall_sprites` is 1.
- R4: While fewer than eight sprites have been found, an in-range sprite has its bytes 0, 1, 2 and 3 written to secondary addresses slot*4+0 to slot*4+3. The slot is the number of sprites found before it.
- R5: While fewer than eight sprites have been found, an out-of-range sprite moves the next read to byte offset 0 of the next sprite index.
- R6: At most eight sprites, which is 32 secondary writes, are stored per line.
- R7: Once eight sprites have been found, an out-of-range byte moves the next read to sprite index + 1 and to byte offset + 1 mod 4.
- R8: Once eight sprites have been found, the first in-range byte read sets the overflow flag and ends the search for that line.
- R9: Reads are acted on, and secondary writes happen, only for dots 65 to 256. Evaluation ends when the sprite index steps past 63.
- R10: On dot 64 the block re-arms: the overflow flag clears, the address returns to 0 and the found count returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low reset |
| dot | input | 9 | Current dot within the line |
| scanline | input | 8 | Line whose sprites are being chosen |
| tall_sprites | input | 1 | 1 selects 16-line sprites |
| oam_addr | output | 8 | Attribute memory read address |
| oam_rdata | input | 8 | Attribute byte at `oam_addr`, same cycle |
| sec_wr | output | 1 | Secondary buffer write strobe |
| sec_addr | output | 5 | Secondary buffer write address |
| sec_data | output | 8 | Secondary buffer write data |
| overflow | output | 1 | Overflow flag |

## Verification
The bound checker watches the following on every cycle:
- the address holds across each two-dot pair;
- the copy-phase skip clears the offset and bumps the index;
- the full-buffer skip bumps both the index and the offset;
- the flag rises only after an in-range read in the search phase;
- writes stay inside the window;
- the found count never exceeds eight;
- the flag clears on the re-arm dot.

Only the bench scenarios can show whole-line results. These are:
- the exact bytes copied and the slot order;
- the full address walk against an independent model;
- the false-positive and false-negative overflow outcomes produced by the skewed search;
- the tall-sprite range;
- a sprite found at index 63 that ends the line as the index wraps.

// File: rtl/sprite_eval_pkg.sv
package sprite_eval_pkg;
  localparam int BYTE_W  = 8;
  localparam int OFS_W   = 2;
  localparam int SHORT_H = 8;
  localparam int TALL_H  = 16;

  typedef enum logic [1:0] {
    STEP_HOLD,
    STEP_BYTE,
    STEP_SPRITE,
    STEP_SKEW
  } step_e;

  typedef enum logic [1:0] {
    EV_IDLE,
    EV_COPY,
    EV_HUNT
  } eval_mode_e;
endpackage

// File: rtl/spr_range_chk.sv
module spr_range_chk
  import sprite_eval_pkg::*;
(
  input  logic [BYTE_W-1:0] line_i,
  input  logic [BYTE_W-1:0] ypos_i,
  input  logic              tall_i,
  output logic              hit_o
);
  localparam logic [BYTE_W-1:0] SHORT_C = BYTE_W'(SHORT_H);
  localparam logic [BYTE_W-1:0] TALL_C  = BYTE_W'(TALL_H);

  logic [BYTE_W-1:0] diff;

  always_comb begin
    diff  = line_i - ypos_i;
    hit_o = diff < (tall_i ? TALL_C : SHORT_C);
  end
endmodule

// File: rtl/spr_addr_walk.sv
module spr_addr_walk
  import sprite_eval_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  step_e            step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             wrap_o
);
  logic [IDX_W-1:0] idx_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ofs_q <= '0;
    end else if (clear_i) begin
      idx_q <= '0;
      ofs_q <= '0;
    end else begin
      unique case (step_i)
        STEP_BYTE:   ofs_q <= ofs_q + 1'b1;
        STEP_SPRITE: begin
          idx_q <= idx_q + 1'b1;
          ofs_q <= '0;
        end
        STEP_SKEW: begin
          idx_q <= idx_q + 1'b1;
          ofs_q <= ofs_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign ofs_o  = ofs_q;
  assign wrap_o = (&idx_q) && (step_i == STEP_SPRITE || step_i == STEP_SKEW);
endmodule

// File: rtl/sprite_eval.sv
module sprite_eval
  import sprite_eval_pkg::*;
#(
  parameter int N_SPR      = 64,
  parameter int SLOTS      = 8,
  parameter int DOT_W      = 9,
  parameter int EVAL_FIRST = 65,
  parameter int EVAL_LAST  = 256
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [DOT_W-1:0]                    dot,
  input  logic [BYTE_W-1:0]                   scanline,
  input  logic                                tall_sprites,
  output logic [$clog2(N_SPR)+OFS_W-1:0]      oam_addr,
  input  logic [BYTE_W-1:0]                   oam_rdata,
  output logic                                sec_wr,
  output logic [$clog2(SLOTS)+OFS_W-1:0]      sec_addr,
  output logic [BYTE_W-1:0]                   sec_data,
  output logic                                overflow
);
  localparam int IDX_W  = $clog2(N_SPR);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [DOT_W-1:0]  FIRST_D   = DOT_W'(EVAL_FIRST);
  localparam logic [DOT_W-1:0]  LAST_D    = DOT_W'(EVAL_LAST);
  localparam logic [DOT_W-1:0]  ARM_D     = DOT_W'(EVAL_FIRST - 1);
  localparam logic              FIRST_ODD = 1'((EVAL_FIRST % 2) != 0);
  localparam logic [SLOT_W:0]   SLOTS_C   = (SLOT_W+1)'(SLOTS);
  localparam logic [OFS_W-1:0]  OFS_LAST  = '1;

  logic              in_win, rd_ph, act, arm, hit, wrap;
  logic [BYTE_W-1:0] data_q;
  logic [IDX_W-1:0]  idx;
  logic [OFS_W-1:0]  ofs;
  step_e             step;
  eval_mode_e        mode_q, mode_n;
  logic [SLOT_W:0]   found_q, found_n;
  logic              ovf_q, ovf_n, wr_c;

  assign in_win = (dot >= FIRST_D) && (dot <= LAST_D);
  assign rd_ph  = in_win && (dot[0] == FIRST_ODD);
  assign act    = in_win && (dot[0] != FIRST_ODD);
  assign arm    = (dot == ARM_D);

  spr_range_chk u_range (
    .line_i (scanline),
    .ypos_i (data_q),
    .tall_i (tall_sprites),
    .hit_o  (hit)
  );

  spr_addr_walk #(.IDX_W(IDX_W)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (arm),
    .step_i  (step),
    .idx_o   (idx),
    .ofs_o   (ofs),
    .wrap_o  (wrap)
  );

  always_comb begin
    step    = STEP_HOLD;
    wr_c    = 1'b0;
    found_n = found_q;
    mode_n  = mode_q;
    ovf_n   = ovf_q;
    if (act) begin
      unique case (mode_q)
        EV_COPY: begin
          if (ofs == '0 && !hit) begin
            step = STEP_SPRITE;
          end else begin
            wr_c = 1'b1;
            if (ofs == OFS_LAST) begin
              step    = STEP_SPRITE;
              found_n = found_q + 1'b1;
              if (found_n == SLOTS_C) mode_n = EV_HUNT;
            end else begin
              step = STEP_BYTE;
            end
          end
        end
        EV_HUNT: begin
          if (hit) begin
            ovf_n  = 1'b1;
            mode_n = EV_IDLE;
          end else begin
            step = STEP_SKEW;
          end
        end
        default: ;
      endcase
      if (wrap) mode_n = EV_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= EV_IDLE;
      found_q <= '0;
      ovf_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (rd_ph) data_q <= oam_rdata;
      if (arm) begin
        mode_q  <= EV_COPY;
        found_q <= '0;
        ovf_q   <= 1'b0;
      end else begin
        mode_q  <= mode_n;
        found_q <= found_n;
        ovf_q   <= ovf_n;
      end
    end
  end

  assign oam_addr = {idx, ofs};
  assign sec_wr   = wr_c;
  assign sec_addr = {found_q[SLOT_W-1:0], ofs};
  assign sec_data = data_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/sprite_eval_chk.sv
module sprite_eval_chk #(
  parameter int ADDR_W     = 8,
  parameter int SLOT_W     = 3,
  parameter int SLOTS      = 8,
  parameter int DOT_W      = 9,
  parameter int EVAL_FIRST = 65,
  parameter int EVAL_LAST  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DOT_W-1:0]  dot,
  input logic [ADDR_W-1:0] oam_addr,
  input logic              sec_wr,
  input logic              overflow,
  input logic              act_s,
  input logic              hit_s,
  input logic              copy_s,
  input logic              hunt_s,
  input logic [SLOT_W:0]   found_s
);
  localparam logic [DOT_W-1:0] FIRST_D = DOT_W'(EVAL_FIRST);
  localparam logic [DOT_W-1:0] LAST_D  = DOT_W'(EVAL_LAST);
  localparam logic [DOT_W-1:0] ARM_D   = DOT_W'(EVAL_FIRST - 1);
  localparam logic FIRST_ODD = 1'((EVAL_FIRST % 2) != 0);

  logic              win, rd_dot;
  logic [ADDR_W-3:0] idx_plus;
  logic [1:0]        ofs_plus;
  assign win      = (dot >= FIRST_D) && (dot <= LAST_D);
  assign rd_dot   = win && (dot[0] == FIRST_ODD);
  assign idx_plus = oam_addr[ADDR_W-1:2] + 1'b1;
  assign ofs_plus = oam_addr[1:0] + 2'd1;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dot |=> $stable(oam_addr));

  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_s && copy_s && oam_addr[1:0] == 2'd0 && !hit_s)
    |=> oam_addr == {$past(idx_plus), 2'b00});

  p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |-> found_s < (SLOT_W+1)'(SLOTS));

  p_skew_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_s && hunt_s && !hit_s)
    |=> oam_addr == {$past(idx_plus), $past(ofs_plus)});

  p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(act_s && hunt_s && hit_s));

  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |-> win);

  p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == ARM_D) |=> (!overflow && oam_addr == '0));
endmodule

bind sprite_eval sprite_eval_chk #(
  .ADDR_W     ($clog2(N_SPR) + 2),
  .SLOT_W     ($clog2(SLOTS)),
  .SLOTS      (SLOTS),
  .DOT_W      (DOT_W),
  .EVAL_FIRST (EVAL_FIRST),
  .EVAL_LAST  (EVAL_LAST)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .dot      (dot),
  .oam_addr (oam_addr),
  .sec_wr   (sec_wr),
  .overflow (overflow),
  .act_s    (act),
  .hit_s    (hit),
  .copy_s   (mode_q == sprite_eval_pkg::EV_COPY),
  .hunt_s   (mode_q == sprite_eval_pkg::EV_HUNT),
  .found_s  (found_q)
);

// File: tb/sprite_eval_tb.sv
`timescale 1ns/1ps
module sprite_eval_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] dot = '0;
  logic [7:0] scanline = '0;
  logic       tall_sprites = 1'b0;
  logic [7:0] oam_addr;
  logic [7:0] oam_rdata;
  logic       sec_wr;
  logic [4:0] sec_addr;
  logic [7:0] sec_data;
  logic       overflow;

  logic [7:0] oam [256];
  logic [7:0] got [32];
  logic [7:0] exp_sec [32];
  logic [7:0] exp_addr [128];
  logic [7:0] rec_addr [96];
  int exp_found, exp_steps, wr_cnt;
  bit exp_ovf;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign oam_rdata = oam[oam_addr];

  sprite_eval dut_i (
    .clk(clk), .rst_n(rst_n), .dot(dot), .scanline(scanline),
    .tall_sprites(tall_sprites), .oam_addr(oam_addr), .oam_rdata(oam_rdata),
    .sec_wr(sec_wr), .sec_addr(sec_addr), .sec_data(sec_data), .overflow(overflow)
  );

  function automatic bit inr(input logic [7:0] y);
    logic [7:0] d;
    d = scanline - y;
    return d < (tall_sprites ? 8'd16 : 8'd8);
  endfunction

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // Independent line model: copy phase, then skewed search.
  task automatic model_line();
    int n, m, found, steps;
    bit stop;
    n = 0; m = 0; found = 0; steps = 0; exp_ovf = 0; stop = 0;
    while (!stop) begin
      if (found < 8) begin
        exp_addr[steps] = 8'(n*4); steps++;
        if (inr(oam[n*4])) begin
          for (int k = 1; k < 4; k++) begin exp_addr[steps] = 8'(n*4+k); steps++; end
          for (int k = 0; k < 4; k++) exp_sec[found*4+k] = oam[n*4+k];
          found++;
        end
        if (n == 63) stop = 1; else n++;
      end else begin
        exp_addr[steps] = 8'(n*4+m); steps++;
        if (inr(oam[n*4+m])) begin exp_ovf = 1; stop = 1; end
        else if (n == 63) stop = 1;
        else begin n++; m = (m + 1) % 4; end
      end
    end
    exp_found = found;
    exp_steps = steps;
  endtask

  task automatic run_line(input logic [7:0] line, input bit tall);
    bit win_bad, hold_bad;
    scanline = line; tall_sprites = tall;
    wr_cnt = 0; win_bad = 0; hold_bad = 0;
    model_line();
    for (int d = 0; d < 341; d++) begin
      dot = 9'(d);
      #1;
      if (sec_wr) begin
        if (d < 65 || d > 256) win_bad = 1;
        got[sec_addr] = sec_data;
        wr_cnt++;
      end
      if (d >= 65 && d <= 256) begin
        if (d % 2 == 1) rec_addr[(d-65)/2] = oam_addr;
        else if (oam_addr != rec_addr[(d-66)/2]) hold_bad = 1;
      end
      if (d == 65) begin
        check(overflow == 1'b0, "R10 flag cleared", int'(overflow), 0);
        check(oam_addr == 8'd0, "R10 address re-armed", int'(oam_addr), 0);
      end
      @(negedge clk);
    end
    check(!win_bad, "R9 writes in window", int'(win_bad), 0);
    check(!hold_bad, "R2 address held over pair", int'(hold_bad), 0);
    check(wr_cnt == exp_found*4, "R3/R6 write count", wr_cnt, exp_found*4);
    for (int i = 0; i < exp_found*4; i++)
      if (got[i] != exp_sec[i]) check(0, "R4 copied byte", int'(got[i]), int'(exp_sec[i]));
    total++;
    for (int i = 0; i < exp_steps && i < 96; i++)
      if (rec_addr[i] != exp_addr[i]) check(0, "R5 R7 address walk", int'(rec_addr[i]), int'(exp_addr[i]));
    total++;
    check(overflow == exp_ovf, "R8 overflow flag", int'(overflow), int'(exp_ovf));
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 256; i++) oam[i] = v;
  endtask

  initial begin
    int seed_dummy;
    logic [7:0] ln;
    seed_dummy = $urandom(32'h5EED);
    fill(8'hFF);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(overflow == 1'b0, "R1 reset flag", int'(overflow), 0);
    check(oam_addr == 8'd0, "R1 reset address", int'(oam_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sec_wr == 1'b0, "R1 no write before window", int'(sec_wr), 0);

    // none in range
    run_line(8'd100, 1'b0);
    // exactly eight in range, rest blank: no flag
    fill(8'hFF);
    for (int s = 0; s < 8; s++) begin oam[s*4] = 8'd50; oam[s*4+1] = 8'(s); oam[s*4+3] = 8'(s+16); end
    run_line(8'd50, 1'b0);
    check(overflow == 1'b0, "R8 eight only", int'(overflow), 0);
    // nine consecutive: flag
    oam[32] = 8'd47;
    run_line(8'd50, 1'b0);
    check(overflow == 1'b1, "R8 ninth sprite", int'(overflow), 1);
    // false negative: sprite 9 in range but skewed read sees byte 1
    fill(8'hFF);
    for (int s = 0; s < 8; s++) oam[s*4] = 8'd50;
    oam[36] = 8'd50;
    run_line(8'd50, 1'b0);
    check(overflow == 1'b0, "R7 skew misses sprite 9", int'(overflow), 0);
    // false positive: sprite 9 byte 1 looks in range
    oam[36] = 8'hFF; oam[37] = 8'd45;
    run_line(8'd50, 1'b0);
    check(overflow == 1'b1, "R7 skew false hit", int'(overflow), 1);
    // tall range: offset 12 only counts in tall mode
    fill(8'hFF);
    oam[20] = 8'd88;
    run_line(8'd100, 1'b0);
    check(wr_cnt == 0, "R3 short excludes 12", wr_cnt, 0);
    run_line(8'd100, 1'b1);
    check(wr_cnt == 4, "R3 tall includes 12", wr_cnt, 4);
    // last sprite in range, wrap ends the line
    fill(8'hFF);
    oam[252] = 8'd10; oam[253] = 8'hA5;
    run_line(8'd12, 1'b0);
    check(got[1] == 8'hA5, "R9 sprite 63 copied", int'(got[1]), 165);
    // random lines
    for (int t = 0; t < 30; t++) begin
      ln = 8'($urandom_range(0, 239));
      for (int i = 0; i < 256; i++) oam[i] = 8'($urandom);
      for (int s = 0; s < 64; s++)
        if ($urandom_range(0, 3) != 0) oam[s*4] = ln - 8'($urandom_range(0, 20));
      run_line(ln, 1'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule